// File: doc/BRIEF.md
# Multi-Page Write Staging Cache

This block buffers a serial write burst on its way from a bus slave controller to a nonvolatile byte array. The cache holds eight lines of eight bytes. The controller loads a start address, then streams data bytes. Each byte lands in the cache slot named by the low six bits of an internal pointer, and the pointer then steps within those six bits. The upper address bits stay fixed for the whole burst. Every byte slot keeps a written mark, and a line counts as loaded as soon as any of its bytes is written.

When the controller reports STOP, every loaded line is copied into the array model. This commit is self-timed: each loaded line takes a fixed number of clock cycles, and busy stays high across all of them. Lines are copied in ascending line order, and only the byte slots that were written are copied. If a new START arrives before STOP, the burst is abandoned and nothing is copied. While busy is high, every request from the controller is dropped.

Top module: `burst_stage_cache`

## Requirements
- R1: After reset, busy_o is 0, ptr_o is 0, line_loaded_o is 0 and every array byte reads 0.
- R2: A pulse on addr_load_i copies addr_i into ptr_o on the next cycle and opens a burst. A data byte offered when no burst is open is ignored: the pointer and the loaded flags do not change.
- R3: Each accepted byte is stored at cache slot ptr_o[5:0]. The low six bits of the pointer then increase by one modulo 64, and ptr_o above bit 5 is unchanged.
- R4: Bit k of line_loaded_o is 1 once any byte has been written to cache line k, where k is ptr_o[5:3] at the time of the write.
- R5: After more than 64 bytes in one burst, the pointer has wrapped to slot 0, and the commit carries the latest byte written to each slot.
- R6: A STOP with at least one loaded line raises busy_o on the next cycle. busy_o then stays high for exactly PAGE_CYC times the number of loaded lines.
- R7: Each loaded line is copied at the end of its own period, in ascending line order. The copy goes to array address {upper pointer bits, line, byte}, and only written slots are copied. All other array bytes keep their values.
- R8: line_loaded_o is all zero in the cycle after busy_o falls.
- R9: While busy_o is high, start, stop, address and data requests have no effect on the pointer, the cache or the commit.
- R10: A START while a burst is open clears all loaded flags. A STOP that follows it commits nothing and leaves the array unchanged.
- R11: A STOP with no loaded line does not raise busy_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START seen on the bus; abandons an open burst |
| stop_i | input | 1 | STOP seen on the bus; commits loaded lines |
| addr_load_i | input | 1 | Load a start address and open a burst |
| addr_i | input | ADDR_W | Start address |
| byte_valid_i | input | 1 | A data byte is offered |
| byte_i | input | 8 | Data byte |
| busy_o | output | 1 | Commit in progress |
| ptr_o | output | ADDR_W | Current address pointer |
| line_loaded_o | output | LINES | One loaded flag per cache line |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array byte at rd_addr_i |

## Verification
The bench builds the block with a 9-bit address and PAGE_CYC set to 3. With these values a full eight-line commit lasts only 24 cycles, and the whole 512-byte array can be swept through the read port every few hundred cycles. Bursts are long enough to wrap the pointer past byte 64, start in the middle of a line, and run through all eight lines. This covers the wrap, partial-line masking and ordered commit cases. Requests are also sent while busy is high, and a burst is abandoned part-way, so that the drop rules are checked against the array contents.

// File: rtl/wc_pkg.sv
package wc_pkg;

   typedef enum logic [0:0] {
      CM_IDLE = 1'b0,
      CM_RUN  = 1'b1
   } commit_st_t;

   // index of the lowest set bit, 0 when none is set
   function automatic int unsigned lowest_set(input logic [31:0] mask);
      int unsigned idx;
      idx = 0;
      for (int i = 31; i >= 0; i--) begin
         if (mask[i]) idx = i;
      end
      return idx;
   endfunction

endpackage

// File: rtl/wc_pointer.sv
module wc_pointer #(
   parameter int ADDR_W  = 10,
   parameter int CACHE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   localparam int UP_W = ADDR_W - CACHE_W;

   logic [UP_W-1:0]    ptr_hi;
   logic [CACHE_W-1:0] ptr_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_hi <= '0;
         ptr_lo <= '0;
      end else if (load) begin
         ptr_hi <= load_addr[ADDR_W-1:CACHE_W];
         ptr_lo <= load_addr[CACHE_W-1:0];
      end else if (step) begin
         ptr_lo <= ptr_lo + 1'b1;
      end
   end

   assign ptr = {ptr_hi, ptr_lo};

   AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ptr[ADDR_W-1:CACHE_W] == $past(ptr[ADDR_W-1:CACHE_W])); // R3
   AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ptr[CACHE_W-1:0] == CACHE_W'($past(ptr[CACHE_W-1:0]) + 1)); // R3
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ptr == $past(load_addr)); // R2

endmodule

// File: rtl/wc_store.sv
module wc_store #(
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [$clog2(LINES*LINE_BYTES)-1:0] waddr,
   input  logic [7:0]                    wdata,
   input  logic                          clr,
   input  logic [$clog2(LINES)-1:0]      rd_line,
   output logic [LINES-1:0]              line_flags,
   output logic [LINE_BYTES*8-1:0]       line_data,
   output logic [LINE_BYTES-1:0]         line_mask
);
   localparam int BYTE_W  = $clog2(LINE_BYTES);
   localparam int CACHE_W = $clog2(LINES*LINE_BYTES);

   logic [LINE_BYTES*8-1:0] lines_data [LINES];
   logic [LINE_BYTES-1:0]   lines_mask [LINES];

   for (genvar gl = 0; gl < LINES; gl++) begin : g_line
      logic [LINE_BYTES-1:0][7:0] dat;
      logic [LINE_BYTES-1:0]      wrote;
      logic                       hit;

      assign hit = we && (waddr[CACHE_W-1:BYTE_W] == (CACHE_W-BYTE_W)'(gl));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wrote <= '0;
         end else if (clr) begin
            wrote <= '0;
         end else if (hit) begin
            wrote[waddr[BYTE_W-1:0]] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit) dat[waddr[BYTE_W-1:0]] <= wdata;
      end

      assign line_flags[gl] = |wrote;
      assign lines_data[gl] = dat;
      assign lines_mask[gl] = wrote;
   end

   assign line_data = lines_data[rd_line];
   assign line_mask = lines_mask[rd_line];

   AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr) |=> line_flags[$past(waddr[CACHE_W-1:BYTE_W])]); // R4
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> line_flags == '0); // R10

endmodule

// File: rtl/wc_commit.sv
module wc_commit
   import wc_pkg::*;
#(
   parameter int LINES    = 8,
   parameter int PAGE_CYC = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   input  logic [LINES-1:0]         flags,
   output logic                     busy,
   output logic                     wr_en,
   output logic [$clog2(LINES)-1:0] wr_line,
   output logic                     done
);
   localparam int LINE_W = $clog2(LINES);

   commit_st_t       state;
   logic [LINES-1:0] pending;
   logic [LINES-1:0] rest;
   logic             tick;

   assign wr_line = LINE_W'(lowest_set(32'(pending)));
   assign rest    = pending & ~(LINES'(1) << wr_line);

   if (PAGE_CYC > 1) begin : g_timer
      localparam int TW = $clog2(PAGE_CYC);
      logic [TW-1:0] timer;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            timer <= '0;
         end else if (state == CM_IDLE || tick) begin
            timer <= '0;
         end else begin
            timer <= timer + 1'b1;
         end
      end

      assign tick = (state == CM_RUN) && (timer == TW'(PAGE_CYC-1));
   end else begin : g_no_timer
      assign tick = (state == CM_RUN);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CM_IDLE;
         pending <= '0;
      end else begin
         case (state)
            CM_IDLE: if (go) begin
               state   <= CM_RUN;
               pending <= flags;
            end
            CM_RUN: if (tick) begin
               pending <= rest;
               if (rest == '0) state <= CM_IDLE;
            end
            default: state <= CM_IDLE;
         endcase
      end
   end

   assign busy  = (state == CM_RUN);
   assign wr_en = tick;
   assign done  = tick && (rest == '0);

   AST_RUN_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pending != '0); // R6
   AST_ONE_LINE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> $countones(pending) == $countones($past(pending)) - 1); // R7
   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R7

endmodule

// File: rtl/wc_array.sv
module wc_array #(
   parameter int ADDR_W     = 10,
   parameter int LINE_BYTES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wr_line_addr,
   input  logic [LINE_BYTES*8-1:0]      wr_data,
   input  logic [LINE_BYTES-1:0]        wr_mask,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [7:0]                   rd_data
);
   localparam int BYTE_W = $clog2(LINE_BYTES);
   localparam int DEPTH  = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         for (int b = 0; b < LINE_BYTES; b++) begin
            if (wr_mask[b]) mem[{wr_line_addr, BYTE_W'(b)}] <= wr_data[b*8 +: 8];
         end
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/burst_stage_cache.sv
module burst_stage_cache #(
   parameter int ADDR_W     = 10,
   parameter int LINES      = 8,
   parameter int LINE_BYTES = 8,
   parameter int PAGE_CYC   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              byte_valid_i,
   input  logic [7:0]        byte_i,
   output logic              busy_o,
   output logic [ADDR_W-1:0] ptr_o,
   output logic [LINES-1:0]  line_loaded_o,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);
   localparam int BYTE_W  = $clog2(LINE_BYTES);
   localparam int LINE_W  = $clog2(LINES);
   localparam int CACHE_W = BYTE_W + LINE_W;

   if ((1 << BYTE_W) != LINE_BYTES) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((1 << LINE_W) != LINES || LINES > 32 || LINES < 2) begin : g_bad_lines
      $error("LINES must be a power of two from 2 to 32");
   end
   if (ADDR_W <= CACHE_W) begin : g_bad_addr
      $error("ADDR_W must exceed the cache index width");
   end
   if (PAGE_CYC < 1) begin : g_bad_page
      $error("PAGE_CYC must be at least one");
   end

   logic accept, ev_start, ev_stop, ev_addr, ev_byte;
   logic burst_open, go, clr;
   logic wr_en, done;
   logic [LINE_W-1:0]       wr_line;
   logic [LINE_BYTES*8-1:0] line_data;
   logic [LINE_BYTES-1:0]   line_mask;

   assign accept   = !busy_o;
   assign ev_start = accept && start_i;
   assign ev_stop  = accept && !start_i && stop_i;
   assign ev_addr  = accept && !start_i && !stop_i && addr_load_i;
   assign ev_byte  = accept && !start_i && !stop_i && !addr_load_i && byte_valid_i && burst_open;
   assign go       = ev_stop && burst_open && (|line_loaded_o);
   assign clr      = ev_start || ev_addr || done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         burst_open <= 1'b0;
      end else if (ev_start || ev_stop) begin
         burst_open <= 1'b0;
      end else if (ev_addr) begin
         burst_open <= 1'b1;
      end
   end

   wc_pointer #(.ADDR_W(ADDR_W), .CACHE_W(CACHE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(ev_addr), .load_addr(addr_i), .step(ev_byte),
      .ptr(ptr_o)
   );

   wc_store #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(ev_byte), .waddr(ptr_o[CACHE_W-1:0]), .wdata(byte_i),
      .clr(clr), .rd_line(wr_line),
      .line_flags(line_loaded_o), .line_data(line_data), .line_mask(line_mask)
   );

   wc_commit #(.LINES(LINES), .PAGE_CYC(PAGE_CYC)) u_commit (
      .clk(clk), .rst_n(rst_n),
      .go(go), .flags(line_loaded_o),
      .busy(busy_o), .wr_en(wr_en), .wr_line(wr_line), .done(done)
   );

   wc_array #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_array (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_line_addr({ptr_o[ADDR_W-1:CACHE_W], wr_line}),
      .wr_data(line_data), .wr_mask(line_mask),
      .rd_addr(rd_addr_i), .rd_data(rd_data_o)
   );

   AST_BUSY_FREEZES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> $stable(ptr_o)); // R9
   AST_FLAGS_CLEAR_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> line_loaded_o == '0); // R8
   AST_NO_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(|line_loaded_o)); // R11
   AST_STRAY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!burst_open && !busy_o && byte_valid_i && !start_i && !stop_i && !addr_load_i)
      |=> $stable(line_loaded_o) && $stable(ptr_o)); // R2

endmodule

// File: tb/burst_stage_cache_bench.sv
module burst_stage_cache_bench;
   localparam int AW = 9;
   localparam int NL = 8;
   localparam int LB = 8;
   localparam int PC = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          start_i = 0, stop_i = 0, addr_load_i = 0, byte_valid_i = 0;
   logic [AW-1:0] addr_i = '0;
   logic [7:0]    byte_i = '0;
   logic          busy_o;
   logic [AW-1:0] ptr_o;
   logic [NL-1:0] line_loaded_o;
   logic [AW-1:0] rd_addr_i = '0;
   logic [7:0]    rd_data_o;

   burst_stage_cache #(.ADDR_W(AW), .LINES(NL), .LINE_BYTES(LB), .PAGE_CYC(PC)) u_burst_stage_cache (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .addr_load_i(addr_load_i), .addr_i(addr_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
      .busy_o(busy_o), .ptr_o(ptr_o), .line_loaded_o(line_loaded_o),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   // behavioural reference
   int m_mem [DEPTH];
   int m_cache [64];
   bit m_val [64];
   int m_ptr, m_timer, m_upper;
   bit m_open, m_busy;
   int m_q [$];

   int    vec = 0, bad = 0;
   string req = "R1";
   bit    started = 0;

   function automatic int m_flags();
      int f;
      f = 0;
      for (int l = 0; l < NL; l++)
         for (int b = 0; b < LB; b++)
            if (m_val[l*LB+b]) f |= (1 << l);
      return f;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
         for (int i = 0; i < 64; i++) m_val[i] = 0;
         m_ptr = 0; m_timer = 0; m_open = 0; m_busy = 0; m_upper = 0;
         m_q.delete();
         started = 1;
      end else if (m_busy) begin
         m_timer++;
         if (m_timer == PC) begin
            int ln;
            ln = m_q.pop_front();
            for (int b = 0; b < LB; b++)
               if (m_val[ln*LB+b]) m_mem[(m_upper << 6) | (ln << 3) | b] = m_cache[ln*LB+b];
            m_timer = 0;
            if (m_q.size() == 0) begin
               m_busy = 0;
               for (int i = 0; i < 64; i++) m_val[i] = 0;
            end
         end
      end else if (start_i) begin
         for (int i = 0; i < 64; i++) m_val[i] = 0;
         m_open = 0;
      end else if (stop_i) begin
         int f;
         f = m_flags();
         if (m_open && f != 0) begin
            for (int l = 0; l < NL; l++) if (f[l]) m_q.push_back(l);
            m_busy = 1; m_timer = 0; m_upper = m_ptr >> 6;
         end
         m_open = 0;
      end else if (addr_load_i) begin
         m_ptr = int'(addr_i);
         for (int i = 0; i < 64; i++) m_val[i] = 0;
         m_open = 1;
      end else if (byte_valid_i && m_open) begin
         m_cache[m_ptr & 63] = int'(byte_i);
         m_val[m_ptr & 63] = 1;
         m_ptr = (m_ptr & ~63) | ((m_ptr + 1) & 63);
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      vec++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare every cycle, then walk the read address
   always @(negedge clk) begin
      if (started) begin
         chk("busy", int'(busy_o), int'(m_busy));
         chk("ptr", int'(ptr_o), m_ptr);
         chk("loaded", int'(line_loaded_o), m_flags());
         chk("array", int'(rd_data_o), m_mem[rd_addr_i]);
         rd_addr_i = rd_addr_i + 1'b1;
      end
   end

   task automatic pulse_start();
      @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
   endtask
   task automatic pulse_stop();
      @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
   endtask
   task automatic load_addr(input int a);
      @(negedge clk); addr_load_i = 1; addr_i = AW'(a); @(negedge clk); addr_load_i = 0;
   endtask
   task automatic send_bytes(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); byte_valid_i = 1; byte_i = 8'((seed + i * 37) & 255);
      end
      @(negedge clk); byte_valid_i = 0;
   endtask
   task automatic burst(input int a, input int n, input int seed);
      pulse_start(); load_addr(a); send_bytes(n, seed); pulse_stop();
   endtask
   task automatic wait_idle();
      for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      req = "R1 reset";
      repeat (4) @(negedge clk);

      req = "R2 stray byte"; // no burst open: ignored
      send_bytes(3, 5);

      req = "R3 R4 R6 R7 single byte";
      burst(9'h05B, 1, 17); wait_idle();

      req = "R3 R4 R6 R7 partial lines";
      burst(9'h0A5, 19, 40); wait_idle();

      req = "R5 R6 R7 R8 wrap";
      burst(9'h1C3, 70, 99); wait_idle();

      req = "R3 R7 full cache";
      burst(9'h140, 64, 3); wait_idle();

      req = "R9 busy drop";
      pulse_start(); load_addr(9'h011); send_bytes(10, 7);
      @(negedge clk); stop_i = 1; @(negedge clk); stop_i = 0;
      load_addr(9'h1F0); send_bytes(4, 200); pulse_start(); pulse_stop();
      wait_idle();

      req = "R10 abort";
      pulse_start(); load_addr(9'h0E0); send_bytes(5, 61); pulse_start(); pulse_stop();
      repeat (6) @(negedge clk);

      req = "R11 empty stop";
      pulse_start(); load_addr(9'h033); pulse_stop();
      repeat (4) @(negedge clk);

      req = "R2 byte after stop";
      send_bytes(4, 11);

      req = "R3 upper bits held";
      burst(9'h1F8, 12, 150); wait_idle();

      req = "R7 final sweep";
      repeat (DEPTH + 8) @(negedge clk);

      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule